// File: doc/BRIEF.md
# Cell Queue Admission with Frame Discard

This block sits in front of a per-connection cell buffer. For each arriving ATM cell it decides whether the cell may be enqueued. For each cell it accepts, it also sets the congestion-notification (EFCI) bit that should travel with the cell. The block keeps one occupancy counter per connection. An accepted cell adds one to it, and a dequeue strobe from the scheduler removes one. Every threshold is a per-connection configuration input.

Each connection runs in one of two congestion modes, chosen by a mode bit. In hysteresis mode, cells with CLP=1 are dropped once the queue has reached a high watermark, and they stay dropped until the queue drains below a low watermark. In frame mode, a four-state machine per connection works at AAL5 frame granularity. It can drop a whole frame when the first cell arrives into a congested queue. It can also drop only the tail of a frame that has already started, while keeping the end-of-frame cell when there is room so that the frame boundary survives. The verdict appears one clock after the cell is presented.

Top module: `cqa_admit`

## Requirements
- R1: A cell arriving while its connection's occupancy is at or above the configured depth is dropped, in either mode.
- R2: In hysteresis mode (mode bit 0), a CLP=1 cell is dropped when occupancy is at or above the CLP high threshold, and is accepted when occupancy is below the CLP low threshold (unless R1 applies). CLP=0 cells are not affected.
- R3: In hysteresis mode, when occupancy lies between the low and high thresholds, a CLP=1 cell is dropped if the high threshold was the last one reached, and accepted if occupancy fell below the low threshold last. Cells already counted are never removed.
- R4: The EFCI output of an accepted cell is 1 exactly when occupancy at arrival is at or above the connection's EFCI threshold. The EFCI output of a dropped cell is 0.
- R5: CLP hysteresis applies only in hysteresis mode, and frame discard applies only in frame mode (mode bit 1).
- R6: In frame mode, a start-of-frame user cell (the first user cell after an end-of-frame cell, or the first after reset) is dropped when occupancy exceeds the EPD0 threshold, or when the cell has CLP=1 and occupancy exceeds the EPD1 threshold. When it is dropped, every user cell of that frame, up to and including the end-of-frame cell, is dropped.
- R7: In frame mode, once a mid-frame user cell of an accepted frame is dropped, the rest of that frame's user cells are dropped. The end-of-frame cell is the exception: it is judged by the depth check of R1 alone.
- R8: In frame mode, if the end-of-frame cell of a partly accepted frame is dropped, the whole next frame is dropped, including its end-of-frame cell, whatever the occupancy.
- R9: Cells with the user-data flag at 0 never change frame-mode state, and are judged by the depth check of R1 alone.
- R10: Occupancy rises by one for each accepted cell and falls by one for each dequeue strobe. An accept and a dequeue on the same connection in the same cycle leave it unchanged. A dequeue at zero occupancy is ignored.
- R11: The verdict (valid, accept, EFCI, connection index) is registered. It appears exactly one cycle after the cell is presented, and the valid output is 0 in the cycle after reset and after any idle input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cell is presented this cycle |
| in_conn | input | CW | Connection index of the cell |
| in_clp | input | 1 | CLP bit of the cell |
| in_eof | input | 1 | Cell ends an AAL5 frame |
| in_user | input | 1 | Cell carries user data |
| deq_valid | input | 1 | Scheduler removed a cell from a queue |
| deq_conn | input | CW | Connection index of the dequeue |
| cfg_frame_mode | input | N | Per-connection mode: 0 hysteresis, 1 frame discard |
| cfg_depth | input | N*W | Per-connection maximum occupancy |
| cfg_clp_hi | input | N*W | Per-connection CLP high threshold |
| cfg_clp_lo | input | N*W | Per-connection CLP low threshold |
| cfg_efci | input | N*W | Per-connection EFCI threshold |
| cfg_epd0 | input | N*W | Per-connection start-of-frame threshold, any CLP |
| cfg_epd1 | input | N*W | Per-connection start-of-frame threshold, CLP=1 |
| dec_valid | output | 1 | Verdict valid |
| dec_accept | output | 1 | 1 enqueue, 0 drop |
| dec_efci | output | 1 | EFCI value for the accepted cell |
| dec_conn | output | CW | Connection index of the verdict |

## Verification
The hardest state to reach from the ports is the one that follows a dropped end-of-frame cell (R8). To get there, a frame must first be accepted at its start. The queue must then fill to its depth in the middle of the frame, and the end-of-frame cell must arrive before any dequeue makes room. The bench uses a connection whose depth is only four cells. It opens a frame on an empty queue, pushes cells until the depth is hit, and presents the end-of-frame cell at full occupancy. It then drains the queue completely and sends another frame, which must still be dropped in full. This shows that the drop comes from remembered state and not from occupancy. A reference model in the bench tracks occupancy, the hysteresis memory and the frame state from the requirements, and it predicts every verdict of the threshold sweeps.

// File: rtl/cqa_pkg.sv
package cqa_pkg;
    typedef enum logic [1:0] {
        PD_WAIT = 2'd0,
        PD_PASS = 2'd1,
        PD_TAIL = 2'd2,
        PD_DROP = 2'd3
    } pd_state_e;
endpackage

// File: rtl/cqa_occ.sv
module cqa_occ #(
    parameter int N  = 4,
    parameter int W  = 5,
    parameter int CW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enq_en,
    input  logic [CW-1:0]       enq_idx,
    input  logic                deq_en,
    input  logic [CW-1:0]       deq_idx,
    output logic [N-1:0][W-1:0] occ
);
    logic [N-1:0][W-1:0] cnt_d, cnt_q;
    logic [N-1:0]        inc_v, dec_v;

    for (genvar i = 0; i < N; i++) begin : g_sel
        assign inc_v[i] = enq_en && (enq_idx == CW'(i));
        assign dec_v[i] = deq_en && (deq_idx == CW'(i));
    end

    always_comb begin
        cnt_d = cnt_q;
        for (int i = 0; i < N; i++) begin
            if (inc_v[i] && !dec_v[i]) begin
                cnt_d[i] = cnt_q[i] + W'(1);
            end else if (dec_v[i] && !inc_v[i] && cnt_q[i] != '0) begin
                cnt_d[i] = cnt_q[i] - W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign occ = cnt_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R10: enqueue alone increments
        a_r10_inc: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_v[i] && !dec_v[i]) |=> cnt_q[i] == $past(cnt_q[i]) + W'(1));
        // R10: enqueue and dequeue together hold
        a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_v[i] && dec_v[i]) |=> $stable(cnt_q[i]));
        // R10: dequeue at zero ignored
        a_r10_floor: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_v[i] && !inc_v[i] && cnt_q[i] == '0) |=> cnt_q[i] == '0);
    end
endmodule

// File: rtl/cqa_hyst.sv
module cqa_hyst #(
    parameter int N = 4,
    parameter int W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0][W-1:0] occ,
    input  logic [N-1:0][W-1:0] hi,
    input  logic [N-1:0][W-1:0] lo,
    output logic [N-1:0]        flag
);
    logic [N-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        for (int i = 0; i < N; i++) begin
            if (occ[i] >= hi[i])     flag_d[i] = 1'b1;
            else if (occ[i] < lo[i]) flag_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
            (occ[i] >= hi[i]) |=> flag_q[i]);
        a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (occ[i] < lo[i] && occ[i] < hi[i]) |=> !flag_q[i]);
    end
endmodule

// File: rtl/cqa_verdict.sv
module cqa_verdict
    import cqa_pkg::*;
#(
    parameter int W = 5
) (
    input  logic [W-1:0] occ,
    input  logic [W-1:0] depth,
    input  logic [W-1:0] clp_hi,
    input  logic [W-1:0] clp_lo,
    input  logic [W-1:0] efci_th,
    input  logic [W-1:0] epd0,
    input  logic [W-1:0] epd1,
    input  logic         frame_mode,
    input  logic         hyst_q,
    input  pd_state_e    state_q,
    input  logic         clp,
    input  logic         eof,
    input  logic         user,
    output logic         accept,
    output logic         efci,
    output pd_state_e    state_d
);
    logic full, hyst_eff, drop;

    assign full     = (occ >= depth);
    assign hyst_eff = (occ >= clp_hi) ? 1'b1 : ((occ < clp_lo) ? 1'b0 : hyst_q);

    always_comb begin
        state_d = state_q;
        drop    = full;
        if (!frame_mode) begin
            drop = full || (clp && hyst_eff);
        end else if (user) begin
            unique case (state_q)
                PD_WAIT: begin
                    drop    = full || (occ > epd0) || (clp && (occ > epd1));
                    state_d = eof ? PD_WAIT : (drop ? PD_DROP : PD_PASS);
                end
                PD_PASS: begin
                    drop = full;
                    if (eof) state_d = drop ? PD_DROP : PD_WAIT;
                    else     state_d = drop ? PD_TAIL : PD_PASS;
                end
                PD_TAIL: begin
                    drop    = eof ? full : 1'b1;
                    state_d = eof ? (drop ? PD_DROP : PD_WAIT) : PD_TAIL;
                end
                PD_DROP: begin
                    drop    = 1'b1;
                    state_d = eof ? PD_WAIT : PD_DROP;
                end
                default: begin
                    drop    = 1'b1;
                    state_d = PD_WAIT;
                end
            endcase
        end
    end

    assign accept = !drop;
    assign efci   = accept && (occ >= efci_th);
endmodule

// File: rtl/cqa_admit.sv
module cqa_admit
    import cqa_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 5,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [CW-1:0]       in_conn,
    input  logic                in_clp,
    input  logic                in_eof,
    input  logic                in_user,
    input  logic                deq_valid,
    input  logic [CW-1:0]       deq_conn,
    input  logic [N-1:0]        cfg_frame_mode,
    input  logic [N-1:0][W-1:0] cfg_depth,
    input  logic [N-1:0][W-1:0] cfg_clp_hi,
    input  logic [N-1:0][W-1:0] cfg_clp_lo,
    input  logic [N-1:0][W-1:0] cfg_efci,
    input  logic [N-1:0][W-1:0] cfg_epd0,
    input  logic [N-1:0][W-1:0] cfg_epd1,
    output logic                dec_valid,
    output logic                dec_accept,
    output logic                dec_efci,
    output logic [CW-1:0]       dec_conn
);
    typedef struct packed {
        logic          vld;
        logic          acc;
        logic          efci;
        logic [CW-1:0] conn;
    } verdict_t;

    verdict_t         out_d, out_q;
    pd_state_e [N-1:0] pd_d, pd_q;

    logic [N-1:0][W-1:0] occ;
    logic [N-1:0]        hyst;
    logic                v_accept, v_efci;
    pd_state_e           v_state;

    cqa_occ #(.N(N), .W(W), .CW(CW)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .enq_en  (in_valid && v_accept),
        .enq_idx (in_conn),
        .deq_en  (deq_valid),
        .deq_idx (deq_conn),
        .occ     (occ)
    );

    cqa_hyst #(.N(N), .W(W)) u_hyst (
        .clk   (clk),
        .rst_n (rst_n),
        .occ   (occ),
        .hi    (cfg_clp_hi),
        .lo    (cfg_clp_lo),
        .flag  (hyst)
    );

    cqa_verdict #(.W(W)) u_verdict (
        .occ        (occ[in_conn]),
        .depth      (cfg_depth[in_conn]),
        .clp_hi     (cfg_clp_hi[in_conn]),
        .clp_lo     (cfg_clp_lo[in_conn]),
        .efci_th    (cfg_efci[in_conn]),
        .epd0       (cfg_epd0[in_conn]),
        .epd1       (cfg_epd1[in_conn]),
        .frame_mode (cfg_frame_mode[in_conn]),
        .hyst_q     (hyst[in_conn]),
        .state_q    (pd_q[in_conn]),
        .clp        (in_clp),
        .eof        (in_eof),
        .user       (in_user),
        .accept     (v_accept),
        .efci       (v_efci),
        .state_d    (v_state)
    );

    always_comb begin
        pd_d       = pd_q;
        out_d.vld  = in_valid;
        out_d.acc  = in_valid && v_accept;
        out_d.efci = in_valid && v_efci;
        out_d.conn = in_conn;
        if (in_valid && in_user && cfg_frame_mode[in_conn]) begin
            pd_d[in_conn] = v_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            for (int i = 0; i < N; i++) pd_q[i] <= PD_WAIT;
        end else begin
            out_q <= out_d;
            pd_q  <= pd_d;
        end
    end

    assign dec_valid  = out_q.vld;
    assign dec_accept = out_q.acc;
    assign dec_efci   = out_q.efci;
    assign dec_conn   = out_q.conn;

    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> dec_valid && dec_conn == $past(in_conn));
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !dec_valid);
    a_r1_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && occ[in_conn] >= cfg_depth[in_conn]) |=> !dec_accept);
    a_r2_clp_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_clp && !cfg_frame_mode[in_conn]
         && occ[in_conn] >= cfg_clp_hi[in_conn]) |=> !dec_accept);
    a_r4_efci_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && occ[in_conn] < cfg_efci[in_conn]) |=> !dec_efci);
    a_r6_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_user && cfg_frame_mode[in_conn]
         && pd_q[in_conn] == PD_DROP) |=> !dec_accept);
    a_r9_non_user: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_user) |=> $stable(pd_q));
endmodule

// File: tb/cqa_admit_test.sv
`timescale 1ns/1ps
module cqa_admit_test;
    localparam int N  = 4;
    localparam int W  = 5;
    localparam int CW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_clp = 1'b0, in_eof = 1'b0, in_user = 1'b0;
    logic [CW-1:0] in_conn = '0, deq_conn = '0;
    logic deq_valid = 1'b0;
    logic [N-1:0] cfg_frame_mode;
    logic [N-1:0][W-1:0] cfg_depth, cfg_clp_hi, cfg_clp_lo, cfg_efci, cfg_epd0, cfg_epd1;
    logic dec_valid, dec_accept, dec_efci;
    logic [CW-1:0] dec_conn;

    int checks = 0, fails = 0;
    bit done = 0;
    int m_occ[N];
    bit m_flag[N];
    int m_st[N];

    always #2.5 clk = ~clk;

    cqa_admit #(.N(N), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_conn(in_conn),
        .in_clp(in_clp), .in_eof(in_eof), .in_user(in_user),
        .deq_valid(deq_valid), .deq_conn(deq_conn),
        .cfg_frame_mode(cfg_frame_mode), .cfg_depth(cfg_depth),
        .cfg_clp_hi(cfg_clp_hi), .cfg_clp_lo(cfg_clp_lo), .cfg_efci(cfg_efci),
        .cfg_epd0(cfg_epd0), .cfg_epd1(cfg_epd1),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_efci(dec_efci),
        .dec_conn(dec_conn)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void upd_flag(input int c);
        if (m_occ[c] >= int'(cfg_clp_hi[c]))     m_flag[c] = 1;
        else if (m_occ[c] < int'(cfg_clp_lo[c])) m_flag[c] = 0;
    endfunction

    // reference: states 0 wait, 1 pass, 2 tail, 3 drop
    task automatic send(input int c, input bit clp, input bit eof, input bit user,
                        input bit deq, input string tag);
        int  o = m_occ[c];
        bit  full = o >= int'(cfg_depth[c]);
        bit  heff = (o >= int'(cfg_clp_hi[c])) ? 1'b1 : ((o < int'(cfg_clp_lo[c])) ? 1'b0 : m_flag[c]);
        bit  drop = full;
        bit  acc, ef;
        int  ns = m_st[c];
        if (!cfg_frame_mode[c]) drop = full || (clp && heff);
        else if (user) begin
            case (m_st[c])
                0: begin drop = full || o > int'(cfg_epd0[c]) || (clp && o > int'(cfg_epd1[c]));
                         ns = eof ? 0 : (drop ? 3 : 1); end
                1: begin drop = full; ns = eof ? (drop ? 3 : 0) : (drop ? 2 : 1); end
                2: begin drop = eof ? full : 1'b1; ns = eof ? (drop ? 3 : 0) : 2; end
                default: begin drop = 1; ns = eof ? 0 : 3; end
            endcase
        end
        acc = !drop;
        ef  = acc && o >= int'(cfg_efci[c]);
        @(negedge clk);
        in_valid = 1; in_conn = CW'(c); in_clp = clp; in_eof = eof; in_user = user;
        deq_valid = deq; deq_conn = CW'(c);
        @(negedge clk);
        in_valid = 0; deq_valid = 0;
        chk(dec_valid && dec_conn == CW'(c), {tag, " R11 valid/conn"}, int'(dec_conn), c);
        chk(dec_accept == acc, {tag, " accept"}, dec_accept, acc);
        chk(dec_efci == ef, {tag, " R4 efci"}, dec_efci, ef);
        m_st[c] = ns;
        if (acc && !deq) m_occ[c]++;
        else if (deq && !acc && m_occ[c] > 0) m_occ[c]--;
        upd_flag(c);
    endtask

    task automatic deq1(input int c);
        @(negedge clk);
        deq_valid = 1; deq_conn = CW'(c);
        @(negedge clk);
        deq_valid = 0;
        chk(!dec_valid, "R11 idle", dec_valid, 0);
        if (m_occ[c] > 0) m_occ[c]--;
        upd_flag(c);
    endtask

    task automatic drain(input int c);
        while (m_occ[c] > 0) deq1(c);
    endtask

    task automatic frame(input int c, input int len, input bit clp, input string tag);
        for (int k = 0; k < len; k++) send(c, clp, k == len - 1, 1, 0, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // conn0 hysteresis, conn1 frame, conn2 small frame, conn3 hysteresis
        cfg_frame_mode = 4'b0110;
        cfg_depth[0] = 20; cfg_clp_hi[0] = 16; cfg_clp_lo[0] = 12; cfg_efci[0] = 6; cfg_epd0[0] = 1; cfg_epd1[0] = 1;
        cfg_depth[1] = 20; cfg_clp_hi[1] = 2;  cfg_clp_lo[1] = 1;  cfg_efci[1] = 6; cfg_epd0[1] = 10; cfg_epd1[1] = 6;
        cfg_depth[2] = 4;  cfg_clp_hi[2] = 3;  cfg_clp_lo[2] = 2;  cfg_efci[2] = 3; cfg_epd0[2] = 2; cfg_epd1[2] = 1;
        cfg_depth[3] = 10; cfg_clp_hi[3] = 8;  cfg_clp_lo[3] = 6;  cfg_efci[3] = 3; cfg_epd0[3] = 9; cfg_epd1[3] = 9;
        for (int i = 0; i < N; i++) begin m_occ[i] = 0; m_flag[i] = 0; m_st[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!dec_valid && !dec_accept, "R11 reset", dec_valid, 0);

        // R1 fill to depth with CLP=0, R4 EFCI across the sweep
        for (int k = 0; k < 22; k++) send(0, 0, 0, 0, 0, "R1 fill");
        send(0, 1, 0, 0, 0, "R2 clp1 at full");
        // R2/R3 drain with CLP=1 probes at every level
        for (int k = 0; k < 20; k++) begin
            deq1(0);
            send(0, 1, 0, 0, 0, "R3 falling sweep");
            if (dec_accept) deq1(0);
        end
        // R2/R3 rising sweep with CLP=1 only
        for (int k = 0; k < 18; k++) send(0, 1, 0, 0, 0, "R3 rising sweep");
        for (int k = 0; k < 6; k++) begin
            deq1(0);
            send(0, 1, 0, 0, 0, "R3 mid-band");
            deq1(0);
        end
        send(0, 0, 0, 0, 0, "R2 clp0 unaffected");
        drain(0);
        // R5 hysteresis mode ignores frame rules (low EPD thresholds)
        for (int k = 0; k < 5; k++) send(0, 0, 0, 0, 0, "R5 setup");
        frame(0, 3, 1, "R5 no frame discard in hyst mode");
        drain(0);

        // R10 simultaneous enqueue/dequeue and dequeue at zero
        deq1(3); deq1(3);
        for (int k = 0; k < 5; k++) send(3, 0, 0, 0, 0, "R10 fill");
        for (int k = 0; k < 6; k++) send(3, 0, 0, 0, 1, "R10 enq+deq");
        for (int k = 0; k < 7; k++) send(3, 0, 0, 0, 0, "R10 count to depth");
        drain(3);

        // R6 frame mode
        frame(1, 4, 0, "R6 first frame accepted");
        for (int k = 0; k < 8; k++) send(1, 1, 0, 0, 0, "R9 non-user fill");
        frame(1, 4, 1, "R6 clp1 over epd1");
        frame(1, 4, 1, "R5 no clp hysteresis in frame mode");
        send(1, 0, 0, 0, 0, "R9 setup");
        send(1, 0, 0, 1, 0, "R6 sof over epd0");
        send(1, 0, 0, 0, 0, "R9 non-user in discard");
        deq1(1); deq1(1); deq1(1); deq1(1); deq1(1); deq1(1);
        send(1, 0, 0, 1, 0, "R6 mid frame dropped");
        send(1, 0, 1, 1, 0, "R6 eof dropped");
        frame(1, 3, 0, "R6 next frame accepted");
        drain(1);

        // R7 tail discard, EOF kept
        for (int k = 0; k < 5; k++) send(2, 0, 0, 1, 0, "R7 fill frame");
        send(2, 0, 0, 1, 0, "R7 tail");
        deq1(2); deq1(2);
        send(2, 0, 0, 1, 0, "R7 tail after room");
        send(2, 0, 1, 1, 0, "R7 eof judged on depth");
        drain(2);
        // R8 EOF dropped at full -> next frame discarded
        for (int k = 0; k < 4; k++) send(2, 0, 0, 1, 0, "R8 fill");
        send(2, 0, 1, 1, 0, "R8 eof at full");
        drain(2);
        frame(2, 3, 0, "R8 following frame discarded");
        frame(2, 2, 0, "R8 recovery frame");
        drain(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule